// File: doc/BRIEF.md
# Packet FIFO with Write Rollback across Two Clocks

This block carries 18-bit words from a write clock domain to a read clock domain and groups them into packets. A producer starts a packet by pulsing a mark input, which saves the current write position. If the producer gives up part way, it pulses a rewind input. The write position then returns to the saved mark, and the abandoned words are dropped before the reader can see any of them. When a packet is whole, the producer pulses commit. Only committed words become visible to the reader, and the number of committed packets rises by one.

The reader sees a first-word-fall-through data port with an empty flag. It also has a packet-ready flag, which stays high while at least one committed packet has not been acknowledged. The reader pulses a done input once per packet it has consumed. A commit carries the committed write position and the number of newly finished packets across the clock boundary together, through a toggle request/acknowledge handshake. The read position comes back to the write domain as a Gray code through a synchronizer. The write side uses it to compute full and almost-full against the live, not yet committed, write position.

Top module: `pkt_cdc_fifo`

## Requirements
- R1: While either reset is asserted, and after both are released with nothing written, rd_empty=1, rd_pkt_ready=0, wr_full=0 and wr_almost_full=0.
- R2: Committed words come out on rd_data in write order, first word fall-through. Words that are written but not yet committed keep rd_empty high.
- R3: A wr_rewind pulse sets the write position back to where it was at the most recent wr_mark, so every word accepted since that mark is discarded.
- R4: rd_pkt_ready is high exactly while the committed packet count exceeds the acknowledged count. Each rd_pkt_done pulse taken while rd_pkt_ready is high lowers the count by one.
- R5: wr_full is high when 2^ADDR_W words are held, counting uncommitted ones. A wr_en while wr_full is high stores nothing.
- R6: wr_almost_full is high when the free entries, seen from the write side, are at most WATERMARK.
- R7: An rd_en while rd_empty is high does not move the read position.
- R8: An rd_pkt_done while rd_pkt_ready is low leaves the packet count at zero.
- R9: When wr_rewind and wr_en are high in the same cycle, the rewind takes priority and the word is not stored. A wr_commit in that cycle is ignored.
- R10: On an idle link, a commit makes its words visible, with rd_empty falling, within 8 read clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Enqueue wr_data this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_mark | input | 1 | Save the write position as packet start |
| wr_rewind | input | 1 | Return the write position to the saved mark |
| wr_commit | input | 1 | Close the packet and publish it to the reader |
| wr_full | output | 1 | No free entry left |
| wr_almost_full | output | 1 | Free entries at or below WATERMARK |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Dequeue the word shown on rd_data |
| rd_data | output | DATA_W | Oldest committed word |
| rd_empty | output | 1 | No committed word to read |
| rd_pkt_ready | output | 1 | At least one unacknowledged committed packet |
| rd_pkt_done | input | 1 | Acknowledge one consumed packet |

## Verification
The bench goes after the rollback corners. It aborts packets at random points, including a rewind that coincides with a write. A design that let a rewind lose to a write, or that published the live pointer, would deliver stray words, and the reader would see data out of sequence. It fills the FIFO to the last entry while nothing is committed. A full flag based on the committed pointer would let the 17th word overwrite unread data, and an off-by-one in the watermark shows up one word early or late. It also sends stray dequeues on an empty FIFO and stray acknowledges with no packet pending. Each of these must leave the pointers and the packet count alone, so a counter that wrapped below zero would show rd_pkt_ready high with nothing pending.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/pkt_fifo_sync.sv
module pkt_fifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pkt_fifo_ram.sv
module pkt_fifo_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_fifo_wr.sv
module pkt_fifo_wr
  import pkt_fifo_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WATERMARK = 2,
  localparam int PW       = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq,
  input  logic              mark,
  input  logic              rewind,
  input  logic              commit,
  input  logic [PW-1:0]     rd_gray_s,
  input  logic              ack_s,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              full,
  output logic              almost_full,
  output logic [PW-1:0]     xfer_ptr,
  output logic [PW-1:0]     xfer_cnt,
  output logic              req
);
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  logic [PW-1:0] wptr_q, wptr_d, snap_q, snap_d;
  logic [PW-1:0] pend_ptr_q, pend_ptr_d, pend_cnt_q, pend_cnt_d;
  logic [PW-1:0] xptr_q, xptr_d, xcnt_q, xcnt_d;
  logic [PW-1:0] rd_bin, used;
  logic          req_q, req_d, accept, commit_ok, idle, launch;

  always_comb begin
    rd_bin      = PW'(gray2bin(32'(rd_gray_s)));
    used        = wptr_q - rd_bin;
    full        = (used == DEPTH_V);
    almost_full = ((DEPTH_V - used) <= PW'(WATERMARK));
    accept      = enq & ~full & ~rewind;
    commit_ok   = commit & ~rewind;
    wptr_d      = rewind ? snap_q : wptr_q + PW'(accept);
    snap_d      = (mark & ~rewind) ? wptr_q : snap_q;
    pend_ptr_d  = commit_ok ? wptr_d : pend_ptr_q;
    idle        = (ack_s == req_q);
    launch      = idle & (pend_cnt_q != '0);
    xptr_d      = launch ? pend_ptr_q : xptr_q;
    xcnt_d      = launch ? pend_cnt_q : xcnt_q;
    req_d       = req_q ^ launch;
    pend_cnt_d  = launch ? PW'(commit_ok) : pend_cnt_q + PW'(commit_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      snap_q     <= '0;
      pend_ptr_q <= '0;
      pend_cnt_q <= '0;
      xptr_q     <= '0;
      xcnt_q     <= '0;
      req_q      <= 1'b0;
    end else begin
      wptr_q     <= wptr_d;
      snap_q     <= snap_d;
      pend_ptr_q <= pend_ptr_d;
      pend_cnt_q <= pend_cnt_d;
      xptr_q     <= xptr_d;
      xcnt_q     <= xcnt_d;
      req_q      <= req_d;
    end
  end

  assign we       = accept;
  assign waddr    = wptr_q[ADDR_W-1:0];
  assign xfer_ptr = xptr_q;
  assign xfer_cnt = xcnt_q;
  assign req      = req_q;

  // R5: live pointer never runs more than a full buffer ahead of the reader
  a_r5_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_V);

  // R3: rewind lands on the saved mark
  a_r3_rewind_to_mark: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (wptr_q == $past(snap_q)));

  // R4: bundle stays stable while a transfer is in flight
  a_r4_bundle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(xptr_q) && $stable(xcnt_q)));
endmodule

// File: rtl/pkt_fifo_rd.sv
module pkt_fifo_rd
  import pkt_fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deq,
  input  logic              pkt_done,
  input  logic              req_s,
  input  logic [PW-1:0]     xfer_ptr,
  input  logic [PW-1:0]     xfer_cnt,
  output logic              empty,
  output logic              pkt_ready,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rd_gray,
  output logic              ack_tgl
);
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  logic [PW-1:0] rptr_q, rptr_d, wlim_q, wlim_d, cnt_q, cnt_d, rgray_q, rgray_d;
  logic          seen_q, seen_d, load, take, drop;

  always_comb begin
    load      = req_s ^ seen_q;
    seen_d    = req_s;
    wlim_d    = load ? xfer_ptr : wlim_q;
    empty     = (rptr_q == wlim_q);
    take      = deq & ~empty;
    rptr_d    = rptr_q + PW'(take);
    rgray_d   = PW'(bin2gray(32'(rptr_d)));
    pkt_ready = (cnt_q != '0);
    drop      = pkt_done & pkt_ready;
    cnt_d     = cnt_q + (load ? xfer_cnt : '0) - PW'(drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      wlim_q  <= '0;
      cnt_q   <= '0;
      rgray_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      wlim_q  <= wlim_d;
      cnt_q   <= cnt_d;
      rgray_q <= rgray_d;
      seen_q  <= seen_d;
    end
  end

  assign raddr   = rptr_q[ADDR_W-1:0];
  assign rd_gray = rgray_q;
  assign ack_tgl = seen_q;

  // R7: dequeue on empty leaves the read position alone
  a_r7_empty_deq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && deq) |=> $stable(rptr_q));

  // R8: stray acknowledge keeps the count at zero
  a_r8_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_ready && pkt_done && !load) |=> !pkt_ready);

  // R4: one acknowledge removes exactly one packet
  a_r4_ack_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && pkt_done && !load) |=> (cnt_q == $past(cnt_q) - PW'(1)));

  // R2: reader never passes the published write limit
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (wlim_q - rptr_q) <= DEPTH_V);
endmodule

// File: rtl/pkt_cdc_fifo.sv
module pkt_cdc_fifo #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 10,
  parameter int WATERMARK   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mark,
  input  logic              wr_rewind,
  input  logic              wr_commit,
  output logic              wr_full,
  output logic              wr_almost_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_pkt_ready,
  input  logic              rd_pkt_done
);
  localparam int PW = ADDR_W + 1;

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     xfer_ptr, xfer_cnt, rd_gray, rd_gray_s;
  logic              req, req_s, ack_tgl, ack_s;

  pkt_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );

  pkt_fifo_wr #(.ADDR_W(ADDR_W), .WATERMARK(WATERMARK)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .enq(wr_en), .mark(wr_mark),
    .rewind(wr_rewind), .commit(wr_commit), .rd_gray_s(rd_gray_s),
    .ack_s(ack_s), .we(we), .waddr(waddr), .full(wr_full),
    .almost_full(wr_almost_full), .xfer_ptr(xfer_ptr),
    .xfer_cnt(xfer_cnt), .req(req)
  );

  pkt_fifo_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .deq(rd_en), .pkt_done(rd_pkt_done),
    .req_s(req_s), .xfer_ptr(xfer_ptr), .xfer_cnt(xfer_cnt),
    .empty(rd_empty), .pkt_ready(rd_pkt_ready), .raddr(raddr),
    .rd_gray(rd_gray), .ack_tgl(ack_tgl)
  );

  pkt_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_rptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  pkt_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_req (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(req), .q(req_s)
  );

  pkt_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(ack_tgl), .q(ack_s)
  );
endmodule

// File: tb/test_pkt_cdc_fifo.sv
module test_pkt_cdc_fifo;
  localparam int AW = 4;
  localparam int DEPTH = 16;
  localparam int WM = 2;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  always #3 wr_clk = ~wr_clk;
  always #2 rd_clk = ~rd_clk;

  logic wr_rst_n, rd_rst_n, wr_en, wr_mark, wr_rewind, wr_commit;
  logic [17:0] wr_data, rd_data;
  logic wr_full, wr_almost_full, rd_en, rd_empty, rd_pkt_ready, rd_pkt_done;

  pkt_cdc_fifo #(.DATA_W(18), .ADDR_W(AW), .WATERMARK(WM)) i_pkt_cdc_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mark(wr_mark), .wr_rewind(wr_rewind), .wr_commit(wr_commit),
    .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_pkt_ready(rd_pkt_ready), .rd_pkt_done(rd_pkt_done)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [17:0] exp_q[$];
  logic [17:0] pend[$];
  int lens[$];
  int snap_len = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int occ();
    return exp_q.size() + pend.size();
  endfunction

  task automatic wcyc(input bit e, input logic [17:0] d, input bit s, input bit r, input bit c);
    @(negedge wr_clk);
    wr_en = e; wr_data = d; wr_mark = s; wr_rewind = r; wr_commit = c;
    if (r) begin
      while (pend.size() > snap_len) void'(pend.pop_back());
    end else begin
      if (s) snap_len = pend.size();
      if (e && occ() < DEPTH) pend.push_back(d);
      if (c) begin
        lens.push_back(pend.size());
        while (pend.size() > 0) exp_q.push_back(pend.pop_front());
        snap_len = 0;
      end
    end
    @(negedge wr_clk);
    wr_en = 0; wr_mark = 0; wr_rewind = 0; wr_commit = 0;
  endtask

  task automatic settle();
    repeat (16) @(negedge rd_clk);
  endtask

  task automatic rd_word(input string req);
    @(negedge rd_clk);
    check(req, int'(rd_empty), 0);
    if (exp_q.size() > 0) begin
      check(req, int'(rd_data), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  task automatic pkt_ack();
    @(negedge rd_clk);
    rd_pkt_done = 1;
    @(negedge rd_clk);
    rd_pkt_done = 0;
    if (lens.size() > 0) void'(lens.pop_front());
  endtask

  task automatic drain_pkt(input string req);
    int n;
    n = lens[0];
    for (int i = 0; i < n; i++) rd_word(req);
    pkt_ack();
  endtask

  task automatic send_pkt(input int len, input bit abort);
    bit closed;
    closed = 0;
    wcyc(0, 0, 1, 0, 0);
    for (int i = 0; i < len; i++) begin
      logic [17:0] d;
      d = 18'($urandom);
      if ($urandom % 3 == 0) wcyc(0, 0, 0, 0, 0);
      if (i == len - 1 && ($urandom % 2 == 1)) begin
        if (abort) wcyc(1, d, 0, 1, 0);
        else wcyc(1, d, 0, 0, 1);
        closed = 1;
      end else begin
        wcyc(1, d, 0, 0, 0);
      end
    end
    if (!closed) begin
      if (abort) wcyc(0, 0, 0, 1, 0);
      else wcyc(0, 0, 0, 0, 1);
    end
  endtask

  initial begin
    #200us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'h5eed));
    wr_rst_n = 0; rd_rst_n = 0;
    wr_en = 0; wr_data = 0; wr_mark = 0; wr_rewind = 0; wr_commit = 0;
    rd_en = 0; rd_pkt_done = 0;

    // R1: reset values
    repeat (3) @(negedge wr_clk);
    check("R1 empty", int'(rd_empty), 1);
    check("R1 ready", int'(rd_pkt_ready), 0);
    check("R1 full", int'(wr_full), 0);
    check("R1 afull", int'(wr_almost_full), 0);
    wr_rst_n = 1;
    repeat (3) @(negedge rd_clk);
    rd_rst_n = 1;
    settle();
    check("R1 empty idle", int'(rd_empty), 1);
    check("R1 ready idle", int'(rd_pkt_ready), 0);

    // R2: uncommitted words stay hidden; R10 commit latency
    wcyc(0, 0, 1, 0, 0);
    wcyc(1, 18'h00a1, 0, 0, 0);
    wcyc(1, 18'h00a2, 0, 0, 0);
    wcyc(1, 18'h00a3, 0, 0, 0);
    settle();
    check("R2 hidden", int'(rd_empty), 1);
    check("R4 no pkt yet", int'(rd_pkt_ready), 0);
    wcyc(0, 0, 0, 0, 1);
    lat = 0;
    while (rd_empty && lat < 20) begin
      @(negedge rd_clk);
      lat++;
    end
    check("R10 latency", int'(lat <= 8), 1);
    settle();
    check("R4 ready", int'(rd_pkt_ready), 1);
    drain_pkt("R2 order");
    settle();
    check("R4 ready after ack", int'(rd_pkt_ready), 0);
    check("R2 empty after drain", int'(rd_empty), 1);

    // R3/R9: rewind discards and wins over same-cycle write
    wcyc(0, 0, 1, 0, 0);
    wcyc(1, 18'h0bad1, 0, 0, 0);
    wcyc(1, 18'h0bad2, 0, 1, 1);
    wcyc(0, 0, 1, 0, 0);
    wcyc(1, 18'h00c1, 0, 0, 1);
    settle();
    check("R9 pkt count", int'(rd_pkt_ready), 1);
    drain_pkt("R3 R9 rewound data");
    settle();
    check("R3 empty after rewind pkt", int'(rd_empty), 1);
    check("R9 commit ignored", int'(rd_pkt_ready), 0);

    // R7: dequeue on empty is ignored
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    check("R7 still empty", int'(rd_empty), 1);
    wcyc(0, 0, 1, 0, 0);
    wcyc(1, 18'h00d1, 0, 0, 1);
    settle();
    drain_pkt("R7 pointer kept");

    // R8: acknowledge with nothing pending
    settle();
    @(negedge rd_clk); rd_pkt_done = 1;
    @(negedge rd_clk); rd_pkt_done = 0;
    settle();
    check("R8 stray ack", int'(rd_pkt_ready), 0);
    wcyc(0, 0, 1, 0, 0);
    wcyc(1, 18'h00e1, 0, 0, 1);
    settle();
    check("R8 one pkt", int'(rd_pkt_ready), 1);
    drain_pkt("R8 data");
    settle();
    check("R8 back to zero", int'(rd_pkt_ready), 0);

    // R5/R6: fill with uncommitted words
    wcyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 13; i++) wcyc(1, 18'(16'h100 + i), 0, 0, 0);
    check("R6 afull at 3 free", int'(wr_almost_full), 0);
    wcyc(1, 18'h10d, 0, 0, 0);
    check("R6 afull at 2 free", int'(wr_almost_full), 1);
    check("R5 not full at 14", int'(wr_full), 0);
    wcyc(1, 18'h10e, 0, 0, 0);
    wcyc(1, 18'h10f, 0, 0, 0);
    check("R5 full at 16", int'(wr_full), 1);
    wcyc(1, 18'h3bad, 0, 0, 0);
    wcyc(0, 0, 0, 0, 1);
    settle();
    for (int i = 0; i < 16; i++) rd_word("R5 full contents");
    pkt_ack();
    settle();
    check("R5 dropped word absent", int'(rd_empty), 1);
    check("R5 full cleared", int'(wr_full), 0);
    check("R6 afull cleared", int'(wr_almost_full), 0);

    // Random packets with aborts (R2, R3, R4, R6)
    for (int round = 0; round < 40; round++) begin
      int npk;
      npk = 1 + int'($urandom % 2);
      for (int p = 0; p < npk; p++) begin
        if ($urandom % 3 == 0) send_pkt(1 + int'($urandom % 5), 1);
        send_pkt(1 + int'($urandom % 5), 0);
      end
      check("R6 random afull", int'(wr_almost_full), 0);
      settle();
      check("R4 random ready", int'(rd_pkt_ready), 1);
      while (lens.size() > 0) begin
        drain_pkt("R2 R3 random data");
        settle();
        check("R4 random count", int'(rd_pkt_ready), int'(lens.size() > 0));
      end
      check("R2 random empty", int'(rd_empty), 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule